// File: doc/BRIEF.md
# Display Link Auxiliary Request Packer

This block turns one auxiliary-channel request from a display-link controller into the byte sequence that a downstream transaction engine puts on the wire. It also turns the engine's outcome into a single result for the requester. A request is made of a 20-bit target address, a 4-bit request code, a payload length, a flat payload vector and the size of the caller's receive buffer. The block checks the request first. It then emits a four-byte header, followed by the payload when the request is a write. Bytes go out one per accepted valid/ready handshake. The block then waits for the engine to report a status, an acknowledge byte and a received-byte count.

The count nibble in the header is only four bits wide, so write payloads are capped at 12 bytes. Reads and the general limit allow up to 16 bytes. Requests that break a limit, or that carry an unknown code, are answered at once and put nothing on the stream.

Top module: `aux_req_packer`

## Requirements
- R1: Header byte 0 carries address bits 7:0 and header byte 1 carries address bits 15:8.
- R2: Header byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R3: The low nibble of header byte 3 is the payload length minus one, or 0 when the length is zero.
- R4: The high nibble of header byte 3 is 3 for a zero-length request. Otherwise it is 4 for a read and (4 + length) modulo 16 for a write.
- R5: After acceptance, the four header bytes go out in order, followed by the payload bytes (lowest byte of the payload vector first) when the request is a write. Exactly one byte moves per cycle with txValid and txReady both high. txLast marks the final byte. txLen equals 4 + length for writes and 4 for reads, including zero-length ones.
- R6: The request class is decided with code bit 2 cleared. Values 0000, 0010 and 1000 are writes, and 0001 and 1001 are reads. Any other value yields result code 4 (bad request) and no stream bytes.
- R7: A length above 16 yields result code 3 (too big) whatever the code is, and this check wins over R6. A write longer than 12 also yields code 3. Neither case emits stream bytes.
- R8: While txValid is high and txReady is low, txData and txLast hold their values.
- R9: Engine status 1 yields result code 1 (timeout), and statuses 2 and 3 yield result code 2 (I/O error). Any non-zero result code comes with a count and reply of 0.
- R10: Engine status 0 yields result code 0, with reply equal to the acknowledge byte shifted right by 4. The count is the payload length for writes, and the smaller of the engine's received count and the buffer size for reads.
- R11: The result is a one-cycle resValid pulse. For a rejected request it comes in the cycle after acceptance. Otherwise it comes in the cycle after engValid is seen. reqReady is high only while no request is in progress, which includes after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle |
| reqCode | input | 4 | Request code |
| reqAddr | input | 20 | Target address |
| reqLen | input | 5 | Payload length in bytes |
| reqBufSize | input | 5 | Caller receive buffer size |
| reqPayload | input | 128 | Payload, byte k at bits 8k+7:8k |
| txValid | output | 1 | Stream byte valid |
| txReady | input | 1 | Engine takes the byte |
| txData | output | 8 | Stream byte |
| txLast | output | 1 | Final byte of the request |
| txLen | output | 5 | Total bytes in this request |
| engValid | input | 1 | Engine outcome present |
| engStatus | input | 2 | Engine status: 0 ok, 1 timeout, 2/3 error |
| engAck | input | 8 | Returned acknowledge byte |
| engRxCount | input | 5 | Bytes received by the engine |
| resValid | output | 1 | Result pulse |
| resCode | output | 3 | 0 ok, 1 timeout, 2 I/O, 3 too big, 4 bad request |
| resCount | output | 5 | Result byte count |
| resReply | output | 4 | Reply code |

## Verification
The hardest cases to reach are the write of exactly 12 bytes, where the count nibble wraps to zero, and the two rejection paths. In those paths the rejection must win the race against the class decode, for example an unknown code with an oversized length. The stimulus sends these requests directly at the limits, with 12, 13 and 17 bytes and with codes that include the bit 2 flag. A pseudo-random txReady pattern stalls the stream in the middle of header and payload bytes, which exercises the hold rule. Engine replies with a received count above the buffer size drive the clipping path.

// File: rtl/aux_pack_pkg.sv
package aux_pack_pkg;
  localparam int AUX_ADDR_W    = 20;
  localparam int AUX_HDR_BYTES = 4;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_IOERR   = 3'd2,
    RES_TOOBIG  = 3'd3,
    RES_BADREQ  = 3'd4
  } resCode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
    logic reject;
  } strobe_t;
endpackage

// File: rtl/aux_pack_dp.sv
module aux_pack_dp import aux_pack_pkg::*; #(
  parameter int MAX_PAYLOAD = 16,
  parameter int MAX_WRITE   = 12,
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int TXL_W = $clog2(AUX_HDR_BYTES + MAX_PAYLOAD + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [3:0]               reqCode,
  input  logic [AUX_ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]         reqLen,
  input  logic [LEN_W-1:0]         reqBufSize,
  input  logic [8*MAX_PAYLOAD-1:0] reqPayload,
  input  logic [1:0]               engStatus,
  input  logic [7:0]               engAck,
  input  logic [LEN_W-1:0]         engRxCount,
  output logic                     isTooBig,
  output logic                     isBadReq,
  output logic [7:0]               txData,
  output logic                     txLast,
  output logic [TXL_W-1:0]         txLen,
  output resCode_e                 resCode,
  output logic [LEN_W-1:0]         resCount,
  output logic [3:0]               resReply
);
  logic [3:0]       codeBase;
  logic             inWrite, inRead;
  logic [3:0]       lenNib, cntNib;
  logic [TXL_W-1:0] totalTx, txLenNext;

  logic [AUX_HDR_BYTES-1:0][7:0] hdrQ;
  logic [8*MAX_PAYLOAD-1:0]      payQ;
  logic [LEN_W-1:0]              lenQ, bufQ;
  logic                          writeQ;
  logic [TXL_W-1:0]              txLenQ, idxQ, payIdx;

  // request classification straight from the request inputs
  assign codeBase = reqCode & 4'b1011;
  always_comb begin
    inWrite  = (codeBase == 4'b0000) || (codeBase == 4'b0010) || (codeBase == 4'b1000);
    inRead   = (codeBase == 4'b0001) || (codeBase == 4'b1001);
    isTooBig = (32'(reqLen) > MAX_PAYLOAD) || (inWrite && (32'(reqLen) > MAX_WRITE));
    isBadReq = !isTooBig && !(inWrite || inRead);
  end

  // length byte: count nibble on top, length-minus-one below
  always_comb begin
    totalTx   = TXL_W'(AUX_HDR_BYTES) + TXL_W'(reqLen);
    lenNib    = (reqLen == '0) ? 4'd0 : 4'(reqLen - 1'b1);
    cntNib    = (reqLen == '0) ? 4'd3 : (inWrite ? totalTx[3:0] : 4'd4);
    txLenNext = inWrite ? totalTx : TXL_W'(AUX_HDR_BYTES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrQ   <= '0;
      payQ   <= '0;
      lenQ   <= '0;
      bufQ   <= '0;
      writeQ <= 1'b0;
      txLenQ <= TXL_W'(AUX_HDR_BYTES);
      idxQ   <= '0;
    end else if (strb.load) begin
      hdrQ[0] <= reqAddr[7:0];
      hdrQ[1] <= reqAddr[15:8];
      hdrQ[2] <= {reqCode, reqAddr[19:16]};
      hdrQ[3] <= {cntNib, lenNib};
      payQ    <= reqPayload;
      lenQ    <= reqLen;
      bufQ    <= reqBufSize;
      writeQ  <= inWrite;
      txLenQ  <= txLenNext;
      idxQ    <= '0;
    end else if (strb.advance) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign payIdx = idxQ - TXL_W'(AUX_HDR_BYTES);

  always_comb begin
    txData = 8'h00;
    if (idxQ < TXL_W'(AUX_HDR_BYTES)) begin
      txData = hdrQ[idxQ[1:0]];
    end else begin
      for (int k = 0; k < MAX_PAYLOAD; k++) begin
        if (payIdx == TXL_W'(k)) txData = payQ[8*k +: 8];
      end
    end
  end

  assign txLast = (idxQ == txLenQ - 1'b1);
  assign txLen  = txLenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCode  <= RES_OK;
      resCount <= '0;
      resReply <= '0;
    end else if (strb.reject) begin
      resCode  <= isTooBig ? RES_TOOBIG : RES_BADREQ;
      resCount <= '0;
      resReply <= '0;
    end else if (strb.finish) begin
      case (engStatus)
        2'd0: begin
          resCode  <= RES_OK;
          resCount <= writeQ ? lenQ : ((engRxCount > bufQ) ? bufQ : engRxCount);
          resReply <= 4'(engAck >> 4);
        end
        2'd1: begin
          resCode  <= RES_TIMEOUT;
          resCount <= '0;
          resReply <= '0;
        end
        default: begin
          resCode  <= RES_IOERR;
          resCount <= '0;
          resReply <= '0;
        end
      endcase
    end
  end

  a_r9_err_clears_fields: assert property (@(posedge clk) disable iff (!rstN)
    (resCode != RES_OK) |-> (resReply == 4'd0) && (resCount == '0));

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= txLenQ);
endmodule

// File: rtl/aux_pack_ctrl.sv
module aux_pack_ctrl import aux_pack_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    isTooBig,
  input  logic    isBadReq,
  output logic    txValid,
  input  logic    txReady,
  input  logic    txLast,
  input  logic    engValid,
  output logic    resValid,
  output strobe_t strb
);
  state_e stateQ, stateD;
  logic   resValidQ;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        if (isTooBig || isBadReq) begin
          strb.reject = 1'b1;
        end else begin
          strb.load = 1'b1;
          stateD    = ST_SEND;
        end
      end
      ST_SEND: if (txReady) begin
        strb.advance = 1'b1;
        if (txLast) stateD = ST_WAIT;
      end
      ST_WAIT: if (engValid) begin
        strb.finish = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      resValidQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      resValidQ <= strb.reject | strb.finish;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign txValid  = (stateQ == ST_SEND);
  assign resValid = resValidQ;

  a_r5_last_ends_stream: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> !txValid);

  a_r7_reject_no_tx: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && (isTooBig || isBadReq)) |=> (!txValid && resValid));

  a_r11_result_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (reqReady && !txValid));
endmodule

// File: rtl/aux_req_packer.sv
module aux_req_packer import aux_pack_pkg::*; #(
  parameter int MAX_PAYLOAD = 16,
  parameter int MAX_WRITE   = 12,
  localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int TXL_W = $clog2(AUX_HDR_BYTES + MAX_PAYLOAD + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [3:0]               reqCode,
  input  logic [AUX_ADDR_W-1:0]    reqAddr,
  input  logic [LEN_W-1:0]         reqLen,
  input  logic [LEN_W-1:0]         reqBufSize,
  input  logic [8*MAX_PAYLOAD-1:0] reqPayload,
  output logic                     txValid,
  input  logic                     txReady,
  output logic [7:0]               txData,
  output logic                     txLast,
  output logic [TXL_W-1:0]         txLen,
  input  logic                     engValid,
  input  logic [1:0]               engStatus,
  input  logic [7:0]               engAck,
  input  logic [LEN_W-1:0]         engRxCount,
  output logic                     resValid,
  output logic [2:0]               resCode,
  output logic [LEN_W-1:0]         resCount,
  output logic [3:0]               resReply
);
  strobe_t  strb;
  logic     isTooBig, isBadReq;
  resCode_e resCodeE;

  aux_pack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .isTooBig (isTooBig),
    .isBadReq (isBadReq),
    .txValid  (txValid),
    .txReady  (txReady),
    .txLast   (txLast),
    .engValid (engValid),
    .resValid (resValid),
    .strb     (strb)
  );

  aux_pack_dp #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .MAX_WRITE   (MAX_WRITE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqCode    (reqCode),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqBufSize (reqBufSize),
    .reqPayload (reqPayload),
    .engStatus  (engStatus),
    .engAck     (engAck),
    .engRxCount (engRxCount),
    .isTooBig   (isTooBig),
    .isBadReq   (isBadReq),
    .txData     (txData),
    .txLast     (txLast),
    .txLen      (txLen),
    .resCode    (resCodeE),
    .resCount   (resCount),
    .resReply   (resReply)
  );

  assign resCode = resCodeE;

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> ($stable(txData) && $stable(txLast)));
endmodule

// File: tb/aux_req_packer_tb_top.sv
module aux_req_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqCode = '0;
  logic [19:0]  reqAddr = '0;
  logic [4:0]   reqLen = '0;
  logic [4:0]   reqBufSize = '0;
  logic [127:0] reqPayload = '0;
  logic         txValid;
  logic         txReady = 1'b0;
  logic [7:0]   txData;
  logic         txLast;
  logic [4:0]   txLen;
  logic         engValid = 1'b0;
  logic [1:0]   engStatus = '0;
  logic [7:0]   engAck = '0;
  logic [4:0]   engRxCount = '0;
  logic         resValid;
  logic [2:0]   resCode;
  logic [4:0]   resCount;
  logic [3:0]   resReply;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_packer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCode(reqCode), .reqAddr(reqAddr), .reqLen(reqLen), .reqBufSize(reqBufSize),
    .reqPayload(reqPayload), .txValid(txValid), .txReady(txReady), .txData(txData),
    .txLast(txLast), .txLen(txLen), .engValid(engValid), .engStatus(engStatus),
    .engAck(engAck), .engRxCount(engRxCount), .resValid(resValid), .resCode(resCode),
    .resCount(resCount), .resReply(resReply)
  );

  typedef struct { logic [7:0] d; logic last; } expByte_t;
  typedef struct { logic [2:0] code; logic [4:0] cnt; logic [3:0] rep; } expRes_t;

  expByte_t byteQ[$];
  int       lenQ[$];
  expRes_t  resQ[$];

  int checks = 0;
  int fails  = 0;
  int resSeen = 0;

  // scripted engine answer for the request in flight
  logic [1:0] sStatus;
  logic [7:0] sAck;
  logic [4:0] sRx;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: computes expectations from the requirements and pushes them
  task automatic sendReq(input logic [3:0] code, input logic [19:0] addr,
                         input int len, input int bufSz, input logic [1:0] st,
                         input logic [7:0] ack, input int rxc, input int seed);
    logic [3:0]   base;
    bit           isW, isR;
    logic [127:0] pay;
    logic [3:0]   lo, hi;
    expRes_t      er;
    int           total;
    int           target;
    base = code & 4'b1011;
    isW  = (base == 4'h0) || (base == 4'h2) || (base == 4'h8);
    isR  = (base == 4'h1) || (base == 4'h9);
    pay  = '0;
    for (int k = 0; k < 16; k++) pay[8*k +: 8] = 8'(seed * 7 + k * 29 + 3);
    er.cnt = 0;
    er.rep = 0;
    if (len > 16 || (isW && len > 12)) begin
      er.code = 3'd3;                            // R7 too big
    end else if (!(isW || isR)) begin
      er.code = 3'd4;                            // R6 bad request
    end else begin
      lo    = (len == 0) ? 4'd0 : 4'(len - 1);
      hi    = (len == 0) ? 4'd3 : (isW ? 4'((4 + len) % 16) : 4'd4);
      total = isW ? 4 + len : 4;
      byteQ.push_back('{addr[7:0], 1'b0});
      byteQ.push_back('{addr[15:8], 1'b0});
      byteQ.push_back('{{code, addr[19:16]}, 1'b0});
      byteQ.push_back('{{hi, lo}, total == 4});
      if (isW) for (int k = 0; k < len; k++) byteQ.push_back('{pay[8*k +: 8], k == len - 1});
      lenQ.push_back(total);
      if (st == 2'd0) begin
        er.code = 3'd0;
        er.cnt  = isW ? 5'(len) : 5'((rxc > bufSz) ? bufSz : rxc);
        er.rep  = ack[7:4];
      end else if (st == 2'd1) begin
        er.code = 3'd1;
      end else begin
        er.code = 3'd2;
      end
    end
    resQ.push_back(er);
    sStatus = st;
    sAck    = ack;
    sRx     = 5'(rxc);
    target  = resSeen + 1;
    @(negedge clk);
    reqCode    = code;
    reqAddr    = addr;
    reqLen     = 5'(len);
    reqBufSize = 5'(bufSz);
    reqPayload = pay;
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    wait (resSeen == target);
    @(negedge clk);
  endtask

  // monitor and engine model
  logic [15:0] lfsr = 16'hACE1;
  int          pos = 0;
  int          engCnt = 0;
  bit          holdPend = 0;
  logic [7:0]  holdD;
  logic        holdL;
  bit          resExpect = 0;
  bit          resDropChk = 0;
  expByte_t    eb;
  expRes_t     rr;
  int          el;
  logic        rdy;
  string       tag;

  always @(negedge clk) begin
    if (!rstN) begin
      txReady  = 1'b0;
      engValid = 1'b0;
    end else begin
      if (holdPend) begin
        if (txValid) chk({txData, txLast} == {holdD, holdL}, "R8", "stalled byte changed",
                         {txData, txLast}, {holdD, holdL});
        holdPend = 0;
      end
      if (resExpect) begin
        chk(resValid == 1'b1, "R11", "result pulse after engine", resValid, 1);
        resExpect  = 0;
        resDropChk = 1;
      end else if (resDropChk) begin
        chk(resValid == 1'b0, "R11", "result pulse width", resValid, 0);
        resDropChk = 0;
      end
      if (resValid) begin
        if (resQ.size() == 0) begin
          chk(0, "R11", "unexpected result", resCode, 7);
        end else begin
          rr = resQ.pop_front();
          case (rr.code)
            3'd0: tag = "R10";
            3'd1, 3'd2: tag = "R9";
            3'd3: tag = "R7";
            default: tag = "R6";
          endcase
          chk(resCode == rr.code, tag, "result code", resCode, rr.code);
          chk(resCount == rr.cnt && resReply == rr.rep, tag, "count/reply",
              {resCount, resReply}, {rr.cnt, rr.rep});
        end
        resSeen++;
      end
      if (engValid) engValid = 1'b0;
      if (engCnt > 0) begin
        engCnt--;
        if (engCnt == 0) begin
          engValid   = 1'b1;
          engStatus  = sStatus;
          engAck     = sAck;
          engRxCount = sRx;
          resExpect  = 1;
        end
      end
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy     = lfsr[0] | lfsr[2];
      txReady = rdy;
      if (txValid && rdy) begin
        if (byteQ.size() == 0) begin
          chk(0, "R7", "byte emitted with none expected", txData, 0);
        end else begin
          eb = byteQ.pop_front();
          case (pos)
            0, 1: tag = "R1";
            2: tag = "R2";
            3: tag = "R4";
            default: tag = "R5";
          endcase
          chk(txData == eb.d, tag, $sformatf("byte %0d", pos), txData, eb.d);
          chk(txLast == eb.last, "R5", "last flag", txLast, eb.last);
          if (pos == 0) begin
            el = lenQ.pop_front();
            chk(txLen == 5'(el), "R5", "transmit length", txLen, el);
            chk(reqReady == 1'b0, "R11", "busy during stream", reqReady, 0);
          end
        end
        if (txLast) begin
          pos    = 0;
          engCnt = 3;
        end else begin
          pos++;
        end
      end else if (txValid) begin
        holdPend = 1;
        holdD    = txData;
        holdL    = txLast;
      end
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && txValid == 1'b0 && resValid == 1'b0, "R11", "reset state",
        {reqReady, txValid, resValid}, 3'b100);

    // R1 R2 R3 R4 R10: native write, 3 bytes
    sendReq(4'h8, 20'h5A3C7, 3, 0, 2'd0, 8'h00, 0, 1);
    // R10: native read 16 bytes, reply 2
    sendReq(4'h9, 20'hFEDCB, 16, 16, 2'd0, 8'h20, 16, 2);
    // R3 R4 R10: address-only read, receive count clipped to buffer
    sendReq(4'h9, 20'h00201, 0, 2, 2'd0, 8'h10, 5, 3);
    // R4: address-only write
    sendReq(4'h8, 20'h12345, 0, 0, 2'd0, 8'h00, 0, 4);
    // R4 R5: 12-byte write, count nibble wraps to 0
    sendReq(4'h8, 20'hABCDE, 12, 0, 2'd0, 8'hF0, 0, 5);
    // R7: write of 13 bytes, read of 17, bad code with 17 bytes
    sendReq(4'h8, 20'h11111, 13, 0, 2'd0, 8'h00, 0, 6);
    sendReq(4'h9, 20'h22222, 17, 16, 2'd0, 8'h00, 0, 7);
    sendReq(4'h3, 20'h33333, 17, 0, 2'd0, 8'h00, 0, 8);
    // R6: unknown codes
    sendReq(4'h3, 20'h44444, 2, 0, 2'd0, 8'h00, 0, 9);
    sendReq(4'hF, 20'h55555, 0, 0, 2'd0, 8'h00, 0, 10);
    // R6: bus write with bit 2 set is still a write
    sendReq(4'h4, 20'h60050, 2, 0, 2'd0, 8'h00, 0, 11);
    // R6: write-status-update class, one byte
    sendReq(4'h2, 20'h70007, 1, 0, 2'd0, 8'h30, 0, 12);
    // R9: timeout and both error statuses
    sendReq(4'h5, 20'h80008, 4, 4, 2'd1, 8'hA0, 4, 13);
    sendReq(4'h1, 20'h90009, 4, 4, 2'd2, 8'hB0, 4, 14);
    sendReq(4'h8, 20'hA000A, 5, 0, 2'd3, 8'hC0, 0, 15);
    // R10: read where received count is below buffer size
    sendReq(4'h1, 20'hB000B, 8, 10, 2'd0, 8'h40, 6, 16);

    repeat (5) @(negedge clk);
    chk(byteQ.size() == 0 && resQ.size() == 0, "R5", "leftover expectations",
        byteQ.size() + resQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule